// File: doc/BRIEF.md
# Timer event capture unit

This block stamps external events with the value of a free-running 16-bit counter. A single asynchronous input pin is brought into the clock domain through a two-stage synchronizer. An optional digital filter can then be placed after it. The filter lets a new pin level through only once four successive samples agree on that level. A selectable edge of the resulting level (rising or falling) copies the counter value into a capture register and sets a sticky capture flag. While the flag is set and the interrupt enable is high, an interrupt request is raised.

The counter advances on every clock where the tick-enable input is high, which allows a prescaler outside the block to drive it. In the normal mode it wraps from 0xFFFF to 0. When the capture register is selected as the counter's period (TOP), the counter wraps to 0 after reaching the captured value. In that mode the pin is disconnected from the capture logic, so no capture takes place and the flag is not touched. The capture flag is cleared by a one-cycle clear strobe. If a new capture arrives in the same cycle as the clear, the capture wins.

Top module: `evt_capture_unit`

## Requirements
- R1: After a synchronous active-low reset the capture register is 0, the flag and interrupt request are 0, and the counter is 0.
- R2: The counter adds 1 on each clock where `tick_en` is 1 and holds otherwise. It wraps from 0xFFFF to 0. With `top_from_capt`=1 it goes to 0 on the tick that finds it equal to the capture register.
- R3: With the filter off, a pin change set up before clock edge E0 triggers its capture at edge E2 (two synchronizer stages plus one edge-detect stage), and not before.
- R4: `edge_rise`=1 selects rising edges of the conditioned pin and `edge_rise`=0 selects falling edges. The other edge causes no capture and leaves the flag at 0.
- R5: With `nc_en`=1, a pin pulse lasting fewer than four clocks causes no capture. A pulse lasting four clocks passes the filter.
- R6: With `nc_en`=1, the capture of a valid edge occurs exactly four clocks later than with the filter off, at edge E6.
- R7: A capture loads `cap_value` with the counter value held just before the capturing edge.
- R8: `cap_flag` is set by a capture and stays set until a clock with `flag_clr`=1. A capture and a clear in the same clock leave the flag set.
- R9: `cap_irq` is 1 exactly while `cap_flag`=1 and `irq_en`=1.
- R10: While `top_from_capt`=1, pin edges change neither `cap_value` nor `cap_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance enable (prescaled tick) |
| cap_pin | input | 1 | Asynchronous event pin |
| nc_en | input | 1 | 1 = insert the four-sample noise filter |
| edge_rise | input | 1 | 1 = rising edge captures, 0 = falling edge captures |
| top_from_capt | input | 1 | 1 = capture register is the counter period; capture disabled |
| irq_en | input | 1 | Capture interrupt enable |
| flag_clr | input | 1 | 1 = clear the capture flag this clock |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The capture event and the flag-clear strobe can both fall in the same clock, and they act on the same flag bit in opposite directions. The bench first clears the flag and then launches a pin edge whose capture edge is known from the latency rules. It raises `flag_clr` in exactly that capture clock. The result is judged at the next falling clock edge: the flag must read 1 and the capture register must hold the counter value expected from the bench's own counter model. A separate plain clear confirms that the strobe alone does take the flag to 0.

// File: rtl/capt_pkg.sv
// Shared definitions for the event capture unit.
// Assumes: edge selection is a single bit, 1 meaning rising.
package capt_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    // Returns 1 when the level transition cur/prev matches the selected edge.
    function automatic logic edge_hit(input logic cur, input logic prev, input edge_sel_e sel);
        return (sel == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/capt_sync.sv
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes: STAGES >= 1; the reset value of every stage is 0.
module capt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
        end else begin : g_chain
            // Shift the pin through the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/capt_filter.sv
// Agreement filter: the output takes a new level only after SAMPLES
// consecutive input samples differ from the present output.
// Assumes: input is already synchronous; SAMPLES >= 2.
module capt_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [CW-1:0] run_q;

    // Count disagreeing samples; flip the output on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b0;
            run_q <= '0;
        end else if (din == dout) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            dout  <= din;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5: the output can only move toward the level last sampled.
    a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> (dout == $past(din)));

    // R5: a sample equal to the output keeps the output unchanged next clock.
    a_r5_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (din == dout) |=> (dout == $past(dout)));

endmodule

// File: rtl/capt_counter.sv
// Free-running timer counter with optional period taken from the
// capture register. Assumes: tick is synchronous to clk.
module capt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap_at_top,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt
);
    // Advance on tick; wrap at top_val in period mode, else naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (wrap_at_top && (cnt == top_val)) cnt <= '0;
            else                                  cnt <= cnt + 1'b1;
        end
    end

    // R2: no tick, no movement.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R2: a tick outside the period match adds exactly one (modulo 2^W).
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wrap_at_top && (cnt == top_val))) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R2: a tick at the period match returns to zero.
    a_r2_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap_at_top && (cnt == top_val)) |=> (cnt == '0));

endmodule

// File: rtl/evt_capture_unit.sv
// Event capture unit: synchronizes and optionally filters one pin,
// detects the selected edge, copies the counter into the capture
// register and keeps a sticky flag with interrupt request.
// Assumes: nc_en is changed only while the pin has been stable for
// longer than the filter window, so the path switch makes no edge.
module evt_capture_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int NC_SAMPLES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cap_pin,
    input  logic             nc_en,
    input  logic             edge_rise,
    input  logic             top_from_capt,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             cap_irq
);
    import capt_pkg::*;

    logic             pin_sync;
    logic             pin_clean;
    logic             pin_sel;
    logic             pin_prev;
    logic             cap_evt;
    logic [CNT_W-1:0] cnt;

    capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_pin),
        .dout  (pin_sync)
    );

    capt_filter #(.SAMPLES(NC_SAMPLES)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_sync),
        .dout  (pin_clean)
    );

    capt_counter #(.W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_en),
        .wrap_at_top (top_from_capt),
        .top_val     (cap_value),
        .cnt         (cnt)
    );

    // Choose the filtered or direct pin level.
    assign pin_sel = nc_en ? pin_clean : pin_sync;

    // Remember last level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_sel;
    end

    // A selected edge captures unless the pin is disconnected (period mode).
    assign cap_evt = edge_hit(pin_sel, pin_prev, edge_sel_e'(edge_rise)) & ~top_from_capt;

    // Load the capture register on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_value <= '0;
        else if (cap_evt) cap_value <= cnt;
    end

    // Sticky flag: capture has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (cap_evt)  cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end

    // Interrupt request while flag and enable are both set.
    assign cap_irq = cap_flag & irq_en;

    // R7 R8: an event loads the counter value and sets the flag.
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_flag && (cap_value == $past(cnt))));

    // R8: without clear the flag never drops.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R8: a clear with no event drops the flag.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt) |=> !cap_flag);

    // R10: in period mode the capture register does not move.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        top_from_capt |=> $stable(cap_value));

    // R10: in period mode the flag cannot rise.
    a_r10_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        top_from_capt |=> !$rose(cap_flag));

    // R9: the request only rises with the enable high.
    a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_irq) |-> (irq_en && cap_flag));

endmodule

// File: tb/evt_capture_unit_tb.sv
`timescale 1ns/1ps
module evt_capture_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, cap_pin, nc_en, edge_rise, top_from_capt, irq_en, flag_clr;
    logic [15:0] cap_value;
    logic        cap_flag, cap_irq;

    int errors = 0;
    int checks = 0;

    logic [15:0] mdl_cnt;
    logic [15:0] mdl_cap;

    always #2 clk = ~clk;

    evt_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_pin(cap_pin),
        .nc_en(nc_en), .edge_rise(edge_rise), .top_from_capt(top_from_capt),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    // Reference counter built from R2.
    always @(posedge clk) begin
        if (!rst_n)       mdl_cnt <= 16'd0;
        else if (tick_en) mdl_cnt <= (top_from_capt && mdl_cnt == mdl_cap) ? 16'd0 : mdl_cnt + 16'd1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive a pin level and check capture timing (R3/R6) and outcome.
    task automatic run_edge(input logic lvl, input logic expect_cap, input string tag);
        logic [15:0] exp_v, old_v;
        int lat;
        clear_flag();
        lat = nc_en ? 6 : 2;
        @(negedge clk) cap_pin = lvl;
        repeat (lat) @(posedge clk);
        @(negedge clk);
        chk({tag, " R3/R6 no early flag"}, cap_flag, 1'b0);
        exp_v = mdl_cnt;
        old_v = cap_value;
        @(posedge clk);
        @(negedge clk);
        if (expect_cap) begin
            chk({tag, " R8 flag set"}, cap_flag, 1'b1);
            chk({tag, " R7 value"}, cap_value, exp_v);
            mdl_cap = exp_v;
        end else begin
            chk({tag, " flag stays 0"}, cap_flag, 1'b0);
            chk({tag, " value kept"}, cap_value, old_v);
        end
        settle(8);
    endtask

    // Pulse the pin high for a given number of clocks (R5).
    task automatic glitch(input int width, input logic expect_cap);
        logic [15:0] old_v;
        clear_flag();
        old_v = cap_value;
        @(negedge clk) cap_pin = 1'b1;
        repeat (width) @(negedge clk);
        cap_pin = 1'b0;
        settle(12);
        chk($sformatf("R5 pulse %0d flag", width), cap_flag, expect_cap);
        if (!expect_cap) chk($sformatf("R5 pulse %0d value", width), cap_value, old_v);
    endtask

    task automatic test_reset();
        settle(1);
        chk("R1 cap_value", cap_value, 16'd0);
        chk("R1 cap_flag", cap_flag, 1'b0);
        chk("R1 cap_irq", cap_irq, 1'b0);
    endtask

    task automatic test_edges();
        edge_rise = 1'b1;
        run_edge(1'b1, 1'b1, "R4 rise sel, rise");
        chk("R9 irq off", cap_irq, 1'b0);
        run_edge(1'b0, 1'b0, "R4 rise sel, fall");
        @(negedge clk) edge_rise = 1'b0;
        run_edge(1'b1, 1'b0, "R4 fall sel, rise");
        run_edge(1'b0, 1'b1, "R4 fall sel, fall");
    endtask

    task automatic test_filter();
        @(negedge clk) begin nc_en = 1'b1; edge_rise = 1'b1; end
        settle(6);
        run_edge(1'b1, 1'b1, "R6 filtered rise");
        run_edge(1'b0, 1'b0, "R6 filtered fall ignored");
        glitch(3, 1'b0);
        glitch(1, 1'b0);
        glitch(4, 1'b1);
        @(negedge clk) nc_en = 1'b0;
        settle(4);
    endtask

    task automatic test_irq_clear();
        @(negedge clk) irq_en = 1'b1;
        #1 chk("R9 irq with flag", cap_irq, 1'b1);
        @(negedge clk) irq_en = 1'b0;
        #1 chk("R9 irq disabled", cap_irq, 1'b0);
        @(negedge clk) irq_en = 1'b1;
        clear_flag();
        chk("R8 plain clear", cap_flag, 1'b0);
        chk("R9 irq after clear", cap_irq, 1'b0);
        @(negedge clk) irq_en = 1'b0;
    endtask

    task automatic test_tick_hold();
        @(negedge clk) tick_en = 1'b0;
        settle(3);
        run_edge(1'b0, 1'b0, "R2 idle fall");
        run_edge(1'b1, 1'b1, "R2 halted counter");
        chk("R2 held count", cap_value, mdl_cnt);
        @(negedge clk) tick_en = 1'b1;
    endtask

    task automatic test_top_mode();
        logic [15:0] period;
        period = mdl_cap;
        @(negedge clk) top_from_capt = 1'b1;
        run_edge(1'b0, 1'b0, "R10 fall");
        run_edge(1'b1, 1'b0, "R10 rise in period mode");
        chk("R10 value kept", cap_value, period);
        run_edge(1'b0, 1'b0, "R10 fall back");
        repeat (70000) @(posedge clk);
        @(negedge clk) top_from_capt = 1'b0;
        settle(2);
        run_edge(1'b1, 1'b1, "R2 after wrap");
        checks++;
        if (cap_value > period) begin
            errors++;
            $display("FAIL R2 period bound: actual=%0h expected<=%0h", cap_value, period);
        end
    endtask

    // Capture and clear in the same clock: the capture wins (R8).
    task automatic test_collision();
        logic [15:0] exp_v;
        run_edge(1'b0, 1'b0, "R8 prep fall");
        clear_flag();
        @(negedge clk) cap_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) begin flag_clr = 1'b1; exp_v = mdl_cnt; end
        @(posedge clk);
        @(negedge clk) flag_clr = 1'b0;
        chk("R8 collision flag", cap_flag, 1'b1);
        chk("R8 collision value", cap_value, exp_v);
    endtask

    initial begin
        #(190000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b1; cap_pin = 1'b0; nc_en = 1'b0; edge_rise = 1'b0;
        top_from_capt = 1'b0; irq_en = 1'b0; flag_clr = 1'b0; mdl_cap = 16'd0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_edges();
        test_filter();
        run_edge(1'b1, 1'b1, "R3 unfiltered rise");
        test_irq_clear();
        test_tick_hold();
        test_top_mode();
        test_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule